// File: doc/BRIEF.md
# Region-Aware CPU/DMA Bus Arbiter

This block decides, in every clock, which of two masters may use each of a set of on-chip targets. By default the targets are program ROM, internal RAM and the peripheral register bus. The DMA master always wins. A DMA cycle claims only the targets it reads from and writes to, and it holds them until it signals completion. The CPU is stalled only when it asks for one of those claimed targets. A CPU access to any other target is granted in the same clock as its request.

The DMA side presents a request together with the region codes of its transfer source and destination. When the arbiter is idle, it grants that request in the same clock. It captures the two regions and keeps them claimed until the clock in which the DMA raises its done input. The CPU side presents a request and one region code, and it holds the request until it is granted. Per-target select vectors tell the fabric which master drives each target.

Top module: `bus_region_arbiter`

## Requirements
- R1: After reset, with no requests, `dma_gnt`, `cpu_gnt`, `tgt_dma_sel` and `tgt_cpu_sel` are all zero.
- R2: When `dma_req` is high and no DMA cycle is in progress, `dma_gnt` is high in that same clock. `tgt_dma_sel` then shows the one-hot decode of the source region ORed with that of the destination region. Region codes are 0 for ROM (bit 0), 1 for RAM (bit 1) and 2 for peripherals (bit 2).
- R3: DMA has priority. A CPU request for a region that the DMA is claiming in its grant clock is not granted in that clock.
- R4: A DMA cycle in progress is never pre-empted. From the clock after the grant through the clock in which `dma_done` is high, `tgt_dma_sel` keeps the captured regions, changes on `dma_src_region` and `dma_dst_region` are ignored, and no new `dma_gnt` is given.
- R5: A CPU request for a region in `tgt_dma_sel` gets no `cpu_gnt` and stays pending.
- R6: While a transfer between peripherals and RAM is active, a CPU request to ROM is granted in the clock it is made.
- R7: While a transfer with both ends on the peripheral bus is active, CPU requests to ROM and to RAM are each granted in the clock they are made.
- R8: A pending CPU request is granted in the first clock after the `dma_done` clock. The exception is a new DMA grant in that clock that claims the same region.
- R9: In every clock, no target is selected for both masters: `tgt_cpu_sel & tgt_dma_sel` is zero.
- R10: Region code 3 names no target. A CPU request with it is never granted, and a DMA source or destination with it adds no bit to `tgt_dma_sel`.
- R11: `tgt_cpu_sel` is the one-hot decode of `cpu_region` when `cpu_gnt` is high and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until granted |
| cpu_region | input | 2 | Target region of the CPU access |
| dma_req | input | 1 | DMA cycle request |
| dma_src_region | input | 2 | Source region of the DMA transfer |
| dma_dst_region | input | 2 | Destination region of the DMA transfer |
| dma_done | input | 1 | DMA cycle completes and releases its targets |
| cpu_gnt | output | 1 | CPU access granted this clock |
| dma_gnt | output | 1 | DMA cycle started this clock |
| tgt_cpu_sel | output | 3 | Per-target select for the CPU |
| tgt_dma_sel | output | 3 | Per-target select for the DMA |

## Verification
The bench targets the clock in which a DMA grant and a CPU request name the same region. A design that let the CPU through there would drive one target from both masters. It changes the DMA region inputs and raises a second DMA request in the middle of a cycle. A design that re-sampled those inputs would free or steal targets, and one that re-granted would start a second cycle. It checks the clock right after release, for the case where the CPU should resume and for the case where a fresh DMA request for the same region wins again. An off-by-one release would show as a stall one clock too long, or as a double grant. Unused region codes are also exercised, because a decoder without a range check would select a target.

// File: rtl/bus_region_arbiter.sv
module bus_region_arbiter #(
  parameter int N_TGT = 3,
  parameter int RW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic [RW-1:0]    cpu_region,
  input  logic             dma_req,
  input  logic [RW-1:0]    dma_src_region,
  input  logic [RW-1:0]    dma_dst_region,
  input  logic             dma_done,
  output logic             cpu_gnt,
  output logic             dma_gnt,
  output logic [N_TGT-1:0] tgt_cpu_sel,
  output logic [N_TGT-1:0] tgt_dma_sel
);

  logic [N_TGT-1:0] cpu_dec, src_dec, dst_dec, claim_new, claim_q;
  logic             busy_q;

  for (genvar g = 0; g < N_TGT; g++) begin : g_dec
    assign cpu_dec[g] = (cpu_region     == RW'(g));
    assign src_dec[g] = (dma_src_region == RW'(g));
    assign dst_dec[g] = (dma_dst_region == RW'(g));
  end

  assign claim_new = src_dec | dst_dec;
  assign dma_gnt   = dma_req & ~busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      claim_q <= '0;
    end else if (dma_gnt) begin
      busy_q  <= 1'b1;
      claim_q <= claim_new;
    end else if (busy_q && dma_done) begin
      busy_q  <= 1'b0;
      claim_q <= '0;
    end
  end

  assign tgt_dma_sel = busy_q ? claim_q : (dma_gnt ? claim_new : '0);
  assign cpu_gnt     = cpu_req & (|cpu_dec) & ~(|(cpu_dec & tgt_dma_sel));
  assign tgt_cpu_sel = cpu_gnt ? cpu_dec : '0;

endmodule

module bus_region_arbiter_chk #(
  parameter int N_TGT = 3,
  parameter int RW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic [RW-1:0]    cpu_region,
  input logic             dma_done,
  input logic             cpu_gnt,
  input logic             dma_gnt,
  input logic [N_TGT-1:0] tgt_cpu_sel,
  input logic [N_TGT-1:0] tgt_dma_sel
);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_cpu_sel & tgt_dma_sel) == '0);

  a_r4_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
    dma_gnt |=> !dma_gnt);

  a_r4_claim_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt || (tgt_dma_sel != '0 && !dma_done && !dma_gnt)) |=> $stable(tgt_dma_sel));

  a_r11_cpu_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_gnt |-> ($countones(tgt_cpu_sel) == 1));

  a_r11_cpu_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_gnt |-> (tgt_cpu_sel == '0));

  a_r10_cpu_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_gnt |-> (cpu_req && (int'(cpu_region) < N_TGT)));

endmodule

bind bus_region_arbiter bus_region_arbiter_chk #(.N_TGT(N_TGT), .RW(RW)) i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_region(cpu_region),
  .dma_done(dma_done), .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt),
  .tgt_cpu_sel(tgt_cpu_sel), .tgt_dma_sel(tgt_dma_sel)
);

// File: tb/test_bus_region_arbiter.sv
module test_bus_region_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_req = 1'b0, dma_req = 1'b0, dma_done = 1'b0;
  logic [1:0] cpu_region = 2'd0, dma_src_region = 2'd0, dma_dst_region = 2'd0;
  logic       cpu_gnt, dma_gnt;
  logic [2:0] tgt_cpu_sel, tgt_dma_sel;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  bus_region_arbiter i_bus_region_arbiter (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_region(cpu_region),
    .dma_req(dma_req), .dma_src_region(dma_src_region), .dma_dst_region(dma_dst_region),
    .dma_done(dma_done), .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt),
    .tgt_cpu_sel(tgt_cpu_sel), .tgt_dma_sel(tgt_dma_sel));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(bit cr, logic [1:0] creg, bit dr, logic [1:0] src, logic [1:0] dst, bit dd);
    @(negedge clk);
    cpu_req = cr; cpu_region = creg; dma_req = dr;
    dma_src_region = src; dma_dst_region = dst; dma_done = dd;
    #2;
    chk("R9 exclusive", {5'd0, tgt_cpu_sel & tgt_dma_sel}, 8'd0);
  endtask

  task automatic t_reset;
    step(0, 0, 0, 0, 0, 0);
    chk("R1 reset dma_gnt", {7'd0, dma_gnt}, 0);
    chk("R1 reset cpu_gnt", {7'd0, cpu_gnt}, 0);
    chk("R1 reset dma_sel", {5'd0, tgt_dma_sel}, 0);
    chk("R1 reset cpu_sel", {5'd0, tgt_cpu_sel}, 0);
    rst_n = 1'b1;
    step(1, 0, 0, 0, 0, 0);
    chk("R11 idle cpu gnt", {7'd0, cpu_gnt}, 1);
    chk("R11 cpu sel rom", {5'd0, tgt_cpu_sel}, 8'h01);
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_periph_ram;
    step(1, 1, 1, 1, 2, 0);
    chk("R2 dma_gnt", {7'd0, dma_gnt}, 1);
    chk("R2 dma sel", {5'd0, tgt_dma_sel}, 8'h06);
    chk("R3 cpu blocked at grant", {7'd0, cpu_gnt}, 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R6 cpu rom granted", {7'd0, cpu_gnt}, 1);
    chk("R4 claim held", {5'd0, tgt_dma_sel}, 8'h06);
    step(1, 1, 1, 0, 0, 0);
    chk("R4 no regrant", {7'd0, dma_gnt}, 0);
    chk("R5 cpu ram pending", {7'd0, cpu_gnt}, 0);
    chk("R4 claim ignores inputs", {5'd0, tgt_dma_sel}, 8'h06);
    step(1, 2, 0, 0, 0, 1);
    chk("R5 cpu periph pending in done clock", {7'd0, cpu_gnt}, 0);
    step(1, 2, 0, 0, 0, 0);
    chk("R8 cpu granted after release", {7'd0, cpu_gnt}, 1);
    chk("R8 dma sel released", {5'd0, tgt_dma_sel}, 0);
    chk("R11 cpu sel periph", {5'd0, tgt_cpu_sel}, 8'h04);
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_periph_only;
    step(0, 0, 1, 2, 2, 0);
    chk("R2 periph-only sel", {5'd0, tgt_dma_sel}, 8'h04);
    step(1, 0, 0, 0, 0, 0);
    chk("R7 cpu rom", {7'd0, cpu_gnt}, 1);
    step(1, 1, 0, 0, 0, 0);
    chk("R7 cpu ram", {7'd0, cpu_gnt}, 1);
    step(1, 2, 0, 0, 0, 1);
    chk("R5 cpu periph blocked", {7'd0, cpu_gnt}, 0);
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_invalid;
    step(1, 3, 0, 0, 0, 0);
    chk("R10 cpu code 3 not granted", {7'd0, cpu_gnt}, 0);
    chk("R10 cpu code 3 no sel", {5'd0, tgt_cpu_sel}, 0);
    step(0, 0, 1, 3, 0, 0);
    chk("R10 dma code 3 adds nothing", {5'd0, tgt_dma_sel}, 8'h01);
    step(1, 1, 0, 0, 0, 1);
    chk("R10 ram free during rom-only dma", {7'd0, cpu_gnt}, 1);
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_rearb;
    step(0, 0, 1, 1, 1, 0);
    step(1, 1, 0, 0, 0, 1);
    chk("R5 ram pending", {7'd0, cpu_gnt}, 0);
    step(1, 1, 1, 1, 0, 0);
    chk("R8 new dma wins release clock", {7'd0, dma_gnt}, 1);
    chk("R3 cpu loses to new dma", {7'd0, cpu_gnt}, 0);
    step(1, 1, 0, 0, 0, 1);
    step(1, 1, 0, 0, 0, 0);
    chk("R8 cpu finally granted", {7'd0, cpu_gnt}, 1);
    step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_periph_ram();
    t_periph_only();
    t_invalid();
    t_rearb();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule